// File: doc/BRIEF.md
# Multi-Width Add-With-Carry Flag ALU

This block adds a destination operand, a source operand and an incoming carry bit at one of four operand sizes: 8, 16, 32 or 64 bits. It returns the sum truncated to the selected size, together with six status flags: overflow, sign, zero, auxiliary carry, carry and parity. One 65-bit adder serves every size. The block masks its inputs to the selected size first, so each size's carry out is a plain bit of the wide sum.

The source can be a register value or an immediate. An immediate comes with its own encoded size of 8, 16 or 32 bits. The block sign-extends it to the destination size before the add. This covers a short immediate added to a wider destination and a 32-bit immediate added to a 64-bit destination. A typical use is the upper limbs of a multi-word addition, where each step takes the previous step's carry as its carry-in.

A parameter selects one of two output forms. With `REG_OUT` set, the result and flags pass through one output register stage that loads whenever `in_valid` is high. With it cleared, the outputs are combinational.

Top module: `adcw_alu`

## Requirements
- R1: The result equals destination plus source plus `cf_i`, truncated to the selected operand size.
- R2: `op_sz_i` selects the operand size: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits and 3 gives 64 bits.
- R3: When `use_imm_i` is high, `src_i` is ignored. In its place, `imm_i` is sign-extended from its encoded size to the operand size. `imm_sz_i` encodes that size: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. An immediate wider than the operand is truncated to the operand size.
- R4: `cf_o` is the unsigned carry out of the top bit of the selected size.
- R5: `of_o` is set when both operands have the same sign at the selected size and the result's sign differs from it. The carry-in is part of this computation.
- R6: `sf_o` equals the most significant bit of the result at the selected size.
- R7: `zf_o` is set exactly when every result bit at the selected size is zero.
- R8: `af_o` is the carry from bit 3 into bit 4 of the addition.
- R9: `pf_o` is set when the low 8 result bits contain an even number of ones.
- R10: Operand bits above the selected size have no effect. Result bits above the selected size are driven to zero.
- R11: With `REG_OUT`=1, the result, the flags and `out_valid` appear on the clock edge that samples `in_valid` high. While reset is active, `out_valid`, the result and all flags are zero.
- R12: With `REG_OUT`=1, a clock edge with `in_valid` low leaves the result and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Register source operand |
| use_imm_i | input | 1 | Take the source from the immediate instead of `src_i` |
| imm_i | input | 32 | Immediate value |
| imm_sz_i | input | 2 | Immediate size: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| op_sz_i | input | 2 | Operand size: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| cf_i | input | 1 | Incoming carry |
| out_valid | output | 1 | Result and flags are valid |
| res_o | output | 64 | Result, zero above the selected size |
| of_o | output | 1 | Signed overflow |
| sf_o | output | 1 | Sign |
| zf_o | output | 1 | Zero |
| af_o | output | 1 | Carry from bit 3 into bit 4 |
| cf_o | output | 1 | Unsigned carry out |
| pf_o | output | 1 | Even parity of the low result byte |

## Verification
The bench builds the block with `REG_OUT`=1. This adds the output register stage, so the one-cycle latency, the reset values and the hold behaviour (R11, R12) can be checked at the ports. Seeded random operands, biased toward all-ones, all-zeros and sign-boundary values, are applied at all four sizes, with both register and immediate sources and every immediate size. The random operands carry garbage above the selected size, which exercises the input masking. Directed cases cover the wrap to zero at each width, carry into the sign bit, and sign extension of a negative immediate into a wider destination.

// File: rtl/adcw_pkg.sv
package adcw_pkg;

    localparam int unsigned XLEN    = 64;
    localparam int unsigned IMM_W   = 32;
    localparam int unsigned NUM_SZ  = 4;
    localparam int unsigned NUM_ISZ = 3;
    localparam int unsigned SZ_W    = 2;

    typedef enum logic [SZ_W-1:0] {
        OPSZ_B = 2'd0,
        OPSZ_W = 2'd1,
        OPSZ_D = 2'd2,
        OPSZ_Q = 2'd3
    } opsz_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic cf;
        logic pf;
    } flags_t;

    function automatic logic [XLEN-1:0] size_mask(input logic [SZ_W-1:0] sz);
        return {XLEN{1'b1}} >> (XLEN - (8 << sz));
    endfunction

    function automatic int unsigned size_bits(input logic [SZ_W-1:0] sz);
        return 8 << sz;
    endfunction

endpackage

// File: rtl/adcw_operands.sv
module adcw_operands
    import adcw_pkg::*;
(
    input  logic [XLEN-1:0]  dst_i,
    input  logic [XLEN-1:0]  src_i,
    input  logic             use_imm_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [SZ_W-1:0]  imm_sz_i,
    input  logic [SZ_W-1:0]  op_sz_i,
    output logic [XLEN-1:0]  a_o,
    output logic [XLEN-1:0]  b_o,
    output logic [XLEN-1:0]  mask_o
);

    logic [XLEN-1:0] mask_tab [NUM_SZ];
    logic [XLEN-1:0] imm_tab  [NUM_ISZ];
    logic [SZ_W-1:0] imm_sel;
    logic [XLEN-1:0] src_raw;

    // One mask per operand size
    for (genvar g = 0; g < NUM_SZ; g++) begin : g_mask
        localparam int unsigned W = 8 << g;
        assign mask_tab[g] = {XLEN{1'b1}} >> (XLEN - W);
    end

    // Immediate sign-extended from each encodable size
    for (genvar k = 0; k < NUM_ISZ; k++) begin : g_imm
        localparam int unsigned IW = 8 << k;
        assign imm_tab[k] = {{(XLEN-IW){imm_i[IW-1]}}, imm_i[IW-1:0]};
    end

    // Size code 3 on the immediate is treated as 32 bits
    assign imm_sel = (imm_sz_i == 2'd3) ? 2'd2 : imm_sz_i;

    always_comb begin
        mask_o  = mask_tab[op_sz_i];
        src_raw = use_imm_i ? imm_tab[imm_sel] : src_i;
        a_o     = dst_i & mask_o;
        b_o     = src_raw & mask_o;
    end

endmodule

// File: rtl/adcw_adder.sv
module adcw_adder
    import adcw_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            cin_i,
    input  logic [SZ_W-1:0] op_sz_i,
    input  logic [XLEN-1:0] mask_i,
    output logic [XLEN-1:0] res_o,
    output logic            co_o,
    output logic            ov_o,
    output logic            sign_o,
    output logic            af_o
);

    logic [XLEN:0]     sum;
    logic [NUM_SZ-1:0] co_v;
    logic [NUM_SZ-1:0] ov_v;
    logic [NUM_SZ-1:0] sg_v;

    // Masked operands make bit W of the sum the carry out at width W
    assign sum = {1'b0, a_i} + {1'b0, b_i} + {{XLEN{1'b0}}, cin_i};

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
        localparam int unsigned W = 8 << g;
        assign co_v[g] = sum[W];
        assign sg_v[g] = sum[W-1];
        assign ov_v[g] = (a_i[W-1] ~^ b_i[W-1]) & (sum[W-1] ^ a_i[W-1]);
    end

    always_comb begin
        res_o  = sum[XLEN-1:0] & mask_i;
        co_o   = co_v[op_sz_i];
        ov_o   = ov_v[op_sz_i];
        sign_o = sg_v[op_sz_i];
        af_o   = a_i[4] ^ b_i[4] ^ sum[4];
    end

endmodule

// File: rtl/adcw_flags.sv
module adcw_flags
    import adcw_pkg::*;
(
    input  logic [XLEN-1:0] res_i,
    input  logic            co_i,
    input  logic            ov_i,
    input  logic            sign_i,
    input  logic            af_i,
    output flags_t          flags_o
);

    always_comb begin
        flags_o.of = ov_i;
        flags_o.sf = sign_i;
        flags_o.zf = ~|res_i;
        flags_o.af = af_i;
        flags_o.cf = co_i;
        flags_o.pf = ~^res_i[7:0];
    end

endmodule

// File: rtl/adcw_alu.sv
module adcw_alu
    import adcw_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [XLEN-1:0]  dst_i,
    input  logic [XLEN-1:0]  src_i,
    input  logic             use_imm_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [SZ_W-1:0]  imm_sz_i,
    input  logic [SZ_W-1:0]  op_sz_i,
    input  logic             cf_i,
    output logic             out_valid,
    output logic [XLEN-1:0]  res_o,
    output logic             of_o,
    output logic             sf_o,
    output logic             zf_o,
    output logic             af_o,
    output logic             cf_o,
    output logic             pf_o
);

    logic [XLEN-1:0] opa_w;
    logic [XLEN-1:0] opb_w;
    logic [XLEN-1:0] mask_w;
    logic [XLEN-1:0] sum_w;
    logic            co_w;
    logic            ov_w;
    logic            sign_w;
    logic            af_w;
    flags_t          flags_w;

    flags_t          flags_q;
    logic [XLEN-1:0] res_q;
    logic            vld_q;
    logic [SZ_W-1:0] sz_q;

    adcw_operands u_ops (
        .dst_i     (dst_i),
        .src_i     (src_i),
        .use_imm_i (use_imm_i),
        .imm_i     (imm_i),
        .imm_sz_i  (imm_sz_i),
        .op_sz_i   (op_sz_i),
        .a_o       (opa_w),
        .b_o       (opb_w),
        .mask_o    (mask_w)
    );

    adcw_adder u_add (
        .a_i     (opa_w),
        .b_i     (opb_w),
        .cin_i   (cf_i),
        .op_sz_i (op_sz_i),
        .mask_i  (mask_w),
        .res_o   (sum_w),
        .co_o    (co_w),
        .ov_o    (ov_w),
        .sign_o  (sign_w),
        .af_o    (af_w)
    );

    adcw_flags u_flg (
        .res_i   (sum_w),
        .co_i    (co_w),
        .ov_i    (ov_w),
        .sign_i  (sign_w),
        .af_i    (af_w),
        .flags_o (flags_w)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q   <= 1'b0;
                res_q   <= '0;
                flags_q <= '0;
                sz_q    <= '0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    res_q   <= sum_w;
                    flags_q <= flags_w;
                    sz_q    <= op_sz_i;
                end
            end
        end

        a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        a_r12_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(res_o) && $stable(cf_o) && $stable(zf_o)));
    end else begin : g_comb
        always_comb begin
            vld_q   = in_valid;
            res_q   = sum_w;
            flags_q = flags_w;
            sz_q    = op_sz_i;
        end
    end

    always_comb begin
        out_valid = vld_q;
        res_o     = res_q;
        of_o      = flags_q.of;
        sf_o      = flags_q.sf;
        zf_o      = flags_q.zf;
        af_o      = flags_q.af;
        cf_o      = flags_q.cf;
        pf_o      = flags_q.pf;
    end

    // Result bits above the size held in the output stage are zero
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((res_o & ~size_mask(sz_q)) == '0));

    // Sign flag tracks the top result bit at the registered size
    a_r6_sign_msb: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sf_o == res_o[size_bits(sz_q)-1]));

    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (zf_o == (res_o == '0)));

    a_r9_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pf_o == ~^res_o[7:0]));

    // An 8-bit immediate fills the bits above it with its sign in a wider operand
    a_r3_imm_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm_i && imm_sz_i == 2'd0 && op_sz_i != 2'd0)
            |-> (opb_w[15:8] == {8{imm_i[7]}}));

    // Overflow needs equal operand signs at the selected width
    a_r5_overflow_signs: assert property (@(posedge clk) disable iff (!rst_n)
        ov_w |-> (opa_w[size_bits(op_sz_i)-1] == opb_w[size_bits(op_sz_i)-1]));

endmodule

// File: tb/sim_adcw_alu.sv
`timescale 1ns/1ps
module sim_adcw_alu;

    typedef struct packed {
        logic [63:0] res;
        logic of, sf, zf, af, cf, pf;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] dst_i = '0, src_i = '0;
    logic        use_imm_i = 1'b0;
    logic [31:0] imm_i = '0;
    logic [1:0]  imm_sz_i = '0, op_sz_i = '0;
    logic        cf_i = 1'b0;
    logic        out_valid;
    logic [63:0] res_o;
    logic        of_o, sf_o, zf_o, af_o, cf_o, pf_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adcw_alu #(.REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .dst_i(dst_i), .src_i(src_i), .use_imm_i(use_imm_i), .imm_i(imm_i),
        .imm_sz_i(imm_sz_i), .op_sz_i(op_sz_i), .cf_i(cf_i),
        .out_valid(out_valid), .res_o(res_o),
        .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .af_o(af_o), .cf_o(cf_o), .pf_o(pf_o)
    );

    function automatic logic [65:0] sx(input logic [63:0] v, input int w);
        logic [65:0] r;
        for (int i = 0; i < 66; i++) r[i] = (i < w) ? v[i] : v[w-1];
        return r;
    endfunction

    function automatic exp_t model(input logic [63:0] d, input logic [63:0] s,
                                   input logic ui, input logic [31:0] im,
                                   input logic [1:0] isz, input logic [1:0] osz,
                                   input logic c);
        exp_t e;
        int w = 8 << osz;
        int iw = (isz == 2'd0) ? 8 : (isz == 2'd1) ? 16 : 32;
        logic [63:0] m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        logic [65:0] sa, sb, t;
        logic [64:0] us;
        logic [63:0] ua, ub;
        logic [4:0]  nib;
        bit same;
        int ones;
        sa = sx(d, w);
        sb = ui ? sx({32'b0, im}, iw) : {2'b0, s};
        sb = sx(sb[63:0], w);
        t  = sa + sb + {65'b0, c};
        ua = d & m;
        ub = sb[63:0] & m;
        us = {1'b0, ua} + {1'b0, ub} + {64'b0, c};
        e.res = t[63:0] & m;
        e.cf  = us[w];
        same = 1'b1;
        for (int i = 0; i < 66; i++) if (i >= w - 1 && t[i] != t[w-1]) same = 1'b0;
        e.of = !same;
        e.sf = e.res[w-1];
        e.zf = (e.res == 64'd0);
        nib  = {1'b0, ua[3:0]} + {1'b0, ub[3:0]} + {4'b0, c};
        e.af = nib[4];
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(e.res[i]);
        e.pf = (ones % 2) == 0;
        return e;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input exp_t e);
        chk("R1/R2/R10 result", res_o, e.res);
        chk("R4 carry", {63'b0, cf_o}, {63'b0, e.cf});
        chk("R5 overflow", {63'b0, of_o}, {63'b0, e.of});
        chk("R6 sign", {63'b0, sf_o}, {63'b0, e.sf});
        chk("R7 zero", {63'b0, zf_o}, {63'b0, e.zf});
        chk("R8 aux carry", {63'b0, af_o}, {63'b0, e.af});
        chk("R9 parity", {63'b0, pf_o}, {63'b0, e.pf});
        chk("R11 out_valid", {63'b0, out_valid}, 64'd1);
    endtask

    // Called at a negedge; checks one clock later at the next negedge
    task automatic do_op(input logic [63:0] d, input logic [63:0] s, input logic ui,
                         input logic [31:0] im, input logic [1:0] isz,
                         input logic [1:0] osz, input logic c);
        exp_t e;
        dst_i = d; src_i = s; use_imm_i = ui; imm_i = im;
        imm_sz_i = isz; op_sz_i = osz; cf_i = c; in_valid = 1'b1;
        e = model(d, s, ui, im, isz, osz, c);
        @(negedge clk);
        check_all(e);
    endtask

    function automatic logic [63:0] pick64();
        case ($urandom_range(0, 5))
            0: return {64{1'b1}};
            1: return 64'd0;
            2: return {$urandom, 32'h7FFF_FF7F};
            3: return {$urandom, 32'h8000_0080};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        int unsigned seed;
        exp_t held;
        seed = $urandom(32'h5EED_0ADC);
        repeat (3) @(negedge clk);
        // R11: reset values
        chk("R11 reset out_valid", {63'b0, out_valid}, 64'd0);
        chk("R11 reset result", res_o, 64'd0);
        chk("R11 reset flags", {58'b0, of_o, sf_o, zf_o, af_o, cf_o, pf_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: 8-bit wrap to zero with carry-in
        do_op(64'hAAAA_0000_0000_00FF, 64'h5555_0000_0000_0000, 1'b0, 32'd0, 2'd0, 2'd0, 1'b1);
        chk("R7 zero on wrap", {63'b0, zf_o}, 64'd1);
        chk("R4 carry on wrap", {63'b0, cf_o}, 64'd1);
        // Directed: carry-in pushes 0x7F into the sign bit
        do_op(64'h7F, 64'h0, 1'b0, 32'd0, 2'd0, 2'd0, 1'b1);
        chk("R5 overflow from carry-in", {63'b0, of_o}, 64'd1);
        // Directed: 64-bit all ones plus carry
        do_op({64{1'b1}}, 64'd0, 1'b0, 32'd0, 2'd0, 2'd3, 1'b1);
        chk("R4 carry at 64 bits", {63'b0, cf_o}, 64'd1);
        // Directed: 16-bit with garbage above the size
        do_op(64'hDEAD_BEEF_0000_FFFF, 64'h1234_5678_9ABC_0001, 1'b0, 32'd0, 2'd0, 2'd1, 1'b0);
        chk("R10 upper bits ignored and zeroed", res_o, 64'd0);
        // Directed: negative 8-bit immediate into 32-bit destination, src_i ignored
        do_op(64'd0, {64{1'b1}}, 1'b1, 32'h0000_0080, 2'd0, 2'd2, 1'b0);
        chk("R3 imm8 to 32", res_o, 64'h0000_0000_FFFF_FF80);
        // Directed: negative 32-bit immediate into 64-bit destination
        do_op(64'd0, 64'd5, 1'b1, 32'h8000_0000, 2'd2, 2'd3, 1'b0);
        chk("R3 imm32 to 64", res_o, 64'hFFFF_FFFF_8000_0000);
        // Directed: 16-bit immediate wider than an 8-bit destination is truncated
        do_op(64'h01, 64'd0, 1'b1, 32'h0000_12FE, 2'd1, 2'd0, 1'b0);
        chk("R3 imm truncated", res_o, 64'h0000_0000_0000_00FF);
        // Directed: nibble carry
        do_op(64'h0F, 64'h01, 1'b0, 32'd0, 2'd0, 2'd1, 1'b0);
        chk("R8 nibble carry", {63'b0, af_o}, 64'd1);

        // R12: in_valid low holds the outputs
        held = '{res: res_o, of: of_o, sf: sf_o, zf: zf_o, af: af_o, cf: cf_o, pf: pf_o};
        in_valid = 1'b0; dst_i = 64'h1; src_i = 64'h1; use_imm_i = 1'b0; op_sz_i = 2'd3;
        @(negedge clk);
        chk("R12 hold result", res_o, held.res);
        chk("R12 hold flags", {58'b0, of_o, sf_o, zf_o, af_o, cf_o, pf_o},
            {58'b0, held.of, held.sf, held.zf, held.af, held.cf, held.pf});
        chk("R11 out_valid drops", {63'b0, out_valid}, 64'd0);

        // Random mix over sizes, sources and immediate sizes
        for (int n = 0; n < 600; n++) begin
            logic ui;
            ui = ($urandom_range(0, 3) == 0);
            do_op(pick64(), pick64(), ui, $urandom, 2'($urandom_range(0, 3)),
                  2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
        end

        in_valid = 1'b0;
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule